// File: doc/BRIEF.md
# Cross-Board Feedback Barrier and Result Broadcaster

This block coordinates a measurement-driven branch that several sequencer boards must take together. Each board raises its arrive line when its sequencer halts at the barrier. Once every enabled board has arrived, the hub issues a one-cycle window-start strobe. The detector path then counts rising edges of the photon pulse input over a programmable number of cycles.

When the window closes, the hub compares the count with a threshold. It forms one result word, a branch bit plus the raw count, and presents it on a broadcast bus for one cycle. Every board endpoint takes the same word at the same clock edge. Each endpoint records the branch decision and pulses its release line, so all enabled sequencers resume in the same cycle.

A latency register holds the number of cycles from window close to release of the most recent exchange. A bench or a monitor can compare it with the 700 ns feedback budget, which is 140 cycles at 200 MHz.

Top module: `fb_exchange_top`

## Requirements
- R1: After reset, win_start_o, res_valid_o, res_branch_o, res_count_o, release_o, branch_o and latency_o are all zero.
- R2: win_start_o is high for exactly one cycle, and only after every board whose enable_i bit is 1 has raised arrive_i. While any enabled board has not arrived, no strobe is issued. Arrive lines of disabled boards are ignored.
- R3: res_count_o equals the number of rising edges (0 then 1 on consecutive clock samples) of pulse_i seen in the win_len_i samples taken on the clock edges that follow the strobe cycle. The sample taken on the strobe edge serves only as the previous value. Pulses before or after the window are not counted, and a window length of 0 gives a count of 0.
- R4: res_branch_o is 1 when res_count_o >= thresh_i, and 0 otherwise. A threshold of 0 therefore always gives 1.
- R5: res_valid_o is high for exactly one cycle per exchange and carries the result word on res_count_o and res_branch_o.
- R6: In the cycle after res_valid_o, release_o equals enable_i for all boards at once, and is zero in the next cycle. Every enabled board's branch_o bit then equals the broadcast res_branch_o.
- R7: latency_o updates one cycle after release to the cycle distance from window close to release. That distance is 2 and never exceeds the 140-cycle budget.
- R8: The broadcast clears all recorded arrivals, so a new exchange starts only after boards arrive again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | N_BOARDS | Boards taking part in the exchange |
| arrive_i | input | N_BOARDS | Per-board barrier arrival |
| pulse_i | input | 1 | Detector photon pulse input |
| win_len_i | input | WIN_W | Counting window length in cycles |
| thresh_i | input | CNT_W | Branch threshold |
| win_start_o | output | 1 | One-cycle window-start strobe |
| res_valid_o | output | 1 | Broadcast result valid |
| res_branch_o | output | 1 | Broadcast branch bit |
| res_count_o | output | CNT_W | Broadcast raw count |
| release_o | output | N_BOARDS | Per-board sequencer release pulse |
| branch_o | output | N_BOARDS | Per-board resolved branch |
| latency_o | output | LAT_W | Close-to-release latency in cycles |

## Verification
Exchanges are run with random pulse patterns and window lengths. The bench drives extra pulses just before and just after each window, so a window boundary that is off by one shows up as a wrong count. Thresholds are chosen at the count, one above it and zero, which separates >= from > and exercises the branch bit in both directions. Arrivals come partly, board by board, and with disabled boards that stay silent, so a barrier that fires early or one that waits for disabled boards is caught. After each exchange an idle period with no arrivals confirms that the recorded arrivals were cleared.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
  typedef enum logic [1:0] {
    PH_BARRIER = 2'd0,
    PH_COUNT   = 2'd1,
    PH_BCAST   = 2'd2
  } phase_e;
endpackage

// File: rtl/fbx_barrier.sv
module fbx_barrier #(
  parameter int N_BOARDS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_BOARDS-1:0] enable_i,
  input  logic [N_BOARDS-1:0] arrive_i,
  input  logic                clear_i,
  output logic                all_in_o
);
  logic [N_BOARDS-1:0] arrived_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      arrived_q <= '0;
    else if (clear_i) arrived_q <= '0;
    else              arrived_q <= arrived_q | (arrive_i & enable_i);
  end

  assign all_in_o = (|enable_i) && (&(arrived_q | ~enable_i));
endmodule

// File: rtl/fbx_window_counter.sv
module fbx_window_counter #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             pulse_q, open_q;
  logic [WIN_W-1:0] rem_q;
  logic             rise;

  assign rise = pulse_i & ~pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      open_q  <= 1'b0;
      rem_q   <= '0;
      count_o <= '0;
      done_o  <= 1'b0;
    end else begin
      pulse_q <= pulse_i;
      done_o  <= 1'b0;
      if (start_i) begin
        count_o <= '0;
        rem_q   <= win_len_i;
        open_q  <= (win_len_i != '0);
        done_o  <= (win_len_i == '0);
      end else if (open_q) begin
        if (rise && count_o != CNT_MAX) count_o <= count_o + 1'b1;
        rem_q <= rem_q - 1'b1;
        if (rem_q == WIN_W'(1)) begin
          open_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fbx_endpoint.sv
module fbx_endpoint (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic en_i,
  input  logic branch_i,
  output logic release_o,
  output logic branch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      release_o <= 1'b0;
      branch_o  <= 1'b0;
    end else begin
      release_o <= go_i & en_i;
      if (go_i && en_i) branch_o <= branch_i;
    end
  end
endmodule

// File: rtl/fb_exchange_top.sv
module fb_exchange_top
  import fbx_pkg::*;
#(
  parameter int N_BOARDS = 4,
  parameter int CNT_W    = 16,
  parameter int WIN_W    = 16,
  parameter int LAT_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_BOARDS-1:0] enable_i,
  input  logic [N_BOARDS-1:0] arrive_i,
  input  logic                pulse_i,
  input  logic [WIN_W-1:0]    win_len_i,
  input  logic [CNT_W-1:0]    thresh_i,
  output logic                win_start_o,
  output logic                res_valid_o,
  output logic                res_branch_o,
  output logic [CNT_W-1:0]    res_count_o,
  output logic [N_BOARDS-1:0] release_o,
  output logic [N_BOARDS-1:0] branch_o,
  output logic [LAT_W-1:0]    latency_o
);
  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

  phase_e           phase_q;
  logic             all_in, win_done;
  logic [CNT_W-1:0] win_count;
  logic             lat_run_q;
  logic [LAT_W-1:0] lat_cnt_q;

  assign win_start_o = (phase_q == PH_BARRIER) && all_in;
  assign res_valid_o = (phase_q == PH_BCAST);

  fbx_barrier #(.N_BOARDS(N_BOARDS)) u_barrier (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .arrive_i(arrive_i),
    .clear_i(res_valid_o), .all_in_o(all_in)
  );

  fbx_window_counter #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(win_start_o), .win_len_i(win_len_i),
    .pulse_i(pulse_i), .count_o(win_count), .done_o(win_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= PH_BARRIER;
      res_count_o  <= '0;
      res_branch_o <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_BARRIER: if (all_in) phase_q <= PH_COUNT;
        PH_COUNT: if (win_done) begin
          res_count_o  <= win_count;
          res_branch_o <= (win_count >= thresh_i);
          phase_q      <= PH_BCAST;
        end
        PH_BCAST: phase_q <= PH_BARRIER;
        default:  phase_q <= PH_BARRIER;
      endcase
    end
  end

  for (genvar b = 0; b < N_BOARDS; b++) begin : g_ep
    fbx_endpoint u_ep (
      .clk_i(clk_i), .rst_ni(rst_ni), .go_i(res_valid_o), .en_i(enable_i[b]),
      .branch_i(res_branch_o), .release_o(release_o[b]), .branch_o(branch_o[b])
    );
  end

  // close-to-release latency meter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_run_q <= 1'b0;
      lat_cnt_q <= '0;
      latency_o <= '0;
    end else if (win_done) begin
      lat_run_q <= 1'b1;
      lat_cnt_q <= LAT_W'(1);
    end else if (lat_run_q) begin
      if (|release_o) begin
        lat_run_q <= 1'b0;
        latency_o <= lat_cnt_q;
      end else if (lat_cnt_q != LAT_MAX) begin
        lat_cnt_q <= lat_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbx_checker.sv
module fbx_checker #(
  parameter int N_BOARDS  = 4,
  parameter int CNT_W     = 16,
  parameter int LAT_W     = 8,
  parameter int LAT_LIMIT = 140
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_BOARDS-1:0] enable_i,
  input logic [CNT_W-1:0]    thresh_i,
  input logic                win_start_o,
  input logic                res_valid_o,
  input logic                res_branch_o,
  input logic [CNT_W-1:0]    res_count_o,
  input logic [N_BOARDS-1:0] release_o,
  input logic [N_BOARDS-1:0] branch_o,
  input logic [LAT_W-1:0]    latency_o
);
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_start_o |=> !win_start_o); // R2
  AST_BRANCH_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_branch_o == (res_count_o >= thresh_i))); // R4
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R5
  AST_RELEASE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> (release_o == enable_i)); // R6
  AST_BRANCH_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> ((branch_o & enable_i) == ({N_BOARDS{$past(res_branch_o)}} & enable_i))); // R6
  AST_RELEASE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|release_o) |=> (release_o == '0)); // R6
  AST_LAT_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(latency_o) <= LAT_LIMIT); // R7
endmodule

bind fb_exchange_top fbx_checker #(
  .N_BOARDS(N_BOARDS), .CNT_W(CNT_W), .LAT_W(LAT_W), .LAT_LIMIT(140)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .thresh_i(thresh_i),
  .win_start_o(win_start_o), .res_valid_o(res_valid_o), .res_branch_o(res_branch_o),
  .res_count_o(res_count_o), .release_o(release_o), .branch_o(branch_o),
  .latency_o(latency_o)
);

// File: tb/sim_fb_exchange_top.sv
`timescale 1ns/1ps
module sim_fb_exchange_top;
  localparam int N = 4;
  localparam int CW = 16;
  localparam int WW = 16;
  localparam int LW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] enable, arrive;
  logic pulse;
  logic [WW-1:0] win_len;
  logic [CW-1:0] thresh;
  logic win_start, res_valid, res_branch;
  logic [CW-1:0] res_count;
  logic [N-1:0] rel, branch;
  logic [LW-1:0] latency;

  int errors = 0, checks = 0, cycles = 0;

  always #2.5 clk = ~clk;

  fb_exchange_top #(.N_BOARDS(N), .CNT_W(CW), .WIN_W(WW), .LAT_W(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .arrive_i(arrive), .pulse_i(pulse),
    .win_len_i(win_len), .thresh_i(thresh), .win_start_o(win_start),
    .res_valid_o(res_valid), .res_branch_o(res_branch), .res_count_o(res_count),
    .release_o(rel), .branch_o(branch), .latency_o(latency)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, act=%0d exp<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_count(input int len, input logic [31:0] pat);
    int c = 0;
    for (int i = 0; i < len; i++)
      if (pat[i] && (i == 0 || !pat[i-1])) c++;
    return c;
  endfunction

  // no strobe in the next n cycles
  task automatic expect_quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (win_start) seen = 1;
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  task automatic exchange(input logic [N-1:0] en, input logic [N-1:0] arr,
                          input int len, input logic [31:0] pat, input int th_mode);
    int ec, th, got;
    bit eb, found;
    ec = exp_count(len, pat);
    th = (th_mode == 0) ? ec : (th_mode == 1) ? ec + 1 : 0;
    eb = (ec >= th);
    @(negedge clk);
    enable = en; win_len = WW'(len); thresh = CW'(th);
    arrive = arr;
    pulse = 1'b1; // pre-window activity, must not count
    found = 0;
    for (int i = 0; i < 20 && !found; i++) begin
      @(negedge clk);
      pulse = ~pulse;
      if (win_start) found = 1;
    end
    check(found, "R2 strobe after full arrival", int'(found), 1);
    pulse = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) check(!win_start, "R2 strobe width", int'(win_start), 0);
      pulse = pat[i];
    end
    @(negedge clk);
    pulse = 1'b1; // post-window pulse, must not count
    found = 0;
    for (int i = 0; i < 10 && !found; i++) begin
      @(negedge clk);
      if (res_valid) found = 1;
    end
    check(found, "R5 result valid", int'(found), 1);
    got = int'(res_count);
    check(got == ec, "R3 count", got, ec);
    check(res_branch == eb, "R4 branch", int'(res_branch), int'(eb));
    arrive = '0; pulse = 1'b0;
    @(negedge clk);
    check(!res_valid, "R5 valid width", int'(res_valid), 0);
    check(rel == en, "R6 release all", int'(rel), int'(en));
    check((branch & en) == ({N{eb}} & en), "R6 branch shared", int'(branch & en),
          int'({N{eb}} & en));
    @(negedge clk);
    check(rel == '0, "R6 release pulse", int'(rel), 0);
    check(latency == LW'(2), "R7 latency", int'(latency), 2);
    check(int'(latency) <= 140, "R7 budget", int'(latency), 140);
    expect_quiet(6, "R8 arrivals cleared");
  endtask

  initial begin
    enable = '0; arrive = '0; pulse = 1'b0; win_len = '0; thresh = '0;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!win_start && !res_valid && !res_branch && res_count == '0 && rel == '0 &&
          branch == '0 && latency == '0, "R1 reset state", int'(rel), 0);

    // partial arrival holds the barrier
    enable = 4'b1111; arrive = 4'b0111;
    expect_quiet(10, "R2 partial arrival");
    exchange(4'b1111, 4'b1111, 8, 32'b1011_0110, 0);

    // disabled boards do not hold the barrier
    exchange(4'b0101, 4'b0101, 5, 32'b11111, 1);
    // disabled board arrivals alone do not start it
    @(negedge clk); enable = 4'b0101; arrive = 4'b1010;
    expect_quiet(8, "R2 disabled ignored");
    arrive = '0;
    exchange(4'b0101, 4'b0101, 1, 32'b1, 0);

    // zero window, zero threshold
    exchange(4'b1111, 4'b1111, 0, 32'hFFFF_FFFF, 2);
    // dense alternating pattern
    exchange(4'b1111, 4'b1111, 32, 32'h5555_5555, 1);

    for (int k = 0; k < 10; k++) begin
      logic [N-1:0] en;
      en = N'($urandom_range(1, 15));
      exchange(en, en, $urandom_range(1, 32), $urandom, $urandom_range(0, 2));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule